// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block decides when the rest of a mixed-signal chip may leave reset. It watches two synchronized comparator flags for the logic supply (Vcc) and the power supply (Vs), plus the sensed level of an open-drain, active-low reset pin that it shares with outside parts. While it holds reset, it pulls the pin low and raises an internal reset. That internal reset parks the motor bridges, turns off the adjustable regulator and returns the serial control register to its default.

Release is slow and deliberate. Both supplies must stay good for a long, parameterized run of clock cycles before the pin is let go, and any bad sample during that run starts the count again. Loss of supply is handled quickly: a Vs drop asserts reset at the next clock edge, and a Vcc dip asserts it once the dip has lasted a short deglitch window. After release, an outside part can force a reset by holding the pin low long enough. The block's own drive of the pin never counts as such a request. Vs uses two flags, one per threshold, and is accepted as good only after the upper threshold has been crossed. All inputs are expected to be synchronous to `clk` already.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While `arstN` is low, `rstPinLowOut` and `coreResetOut` are both 1.
- R2: From holding, reset is released after exactly RELEASE_CYCLES consecutive clock edges at which Vcc is good and Vs is good. Good means `vccOk`=1 and the Vs state of R4 is good.
- R3: A single sample at which either supply is bad, taken while holding, restarts the release count from zero.
- R4: Vs becomes good at an edge where `vsAboveHigh`=1. It stays good while `vsAboveLow`=1, even if `vsAboveHigh` falls. It becomes bad at an edge where both flags are 0. After reset, Vs is bad.
- R5: While released, an edge at which Vs is bad asserts reset at that edge.
- R6: While released, `vccOk`=0 at DEGLITCH_CYCLES consecutive edges asserts reset at the last of them. Shorter dips have no effect.
- R7: While released, `pinSense`=0 at EXT_MIN_CYCLES consecutive edges asserts reset at the last of them. Shorter low pulses have no effect.
- R8: A low pin level seen while the block is holding does not count toward R7. The external count begins only at the first edge after release.
- R9: `coreResetOut` equals `rstPinLowOut` in every cycle, so the internal reset falls in the same cycle the pin is released.
- R10: Every reassertion, whatever its cause, is followed by a full R2 release sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous active-low reset of the sequencer logic |
| vccOk | input | 1 | Vcc above its threshold (synchronized) |
| vsAboveHigh | input | 1 | Vs above its rising threshold (synchronized) |
| vsAboveLow | input | 1 | Vs above its falling threshold (synchronized) |
| pinSense | input | 1 | Sensed level of the shared reset pin (synchronized) |
| rstPinLowOut | output | 1 | 1 = pull the open-drain reset pin low |
| coreResetOut | output | 1 | Internal reset to bridges, regulator enable and serial register |

## Verification
The checker watches several rules on every cycle. The two reset outputs must always agree. A released state with Vs below its lower threshold must lead to reset at the next edge. Holding must continue past any edge where Vcc is bad or Vs is below both thresholds. No release may come sooner than RELEASE_CYCLES held cycles, and no reset may start while released unless there is a cause. The exact lengths are left to the bench's scenarios: the release count and its restart, the boundary between an ignored dip or pulse and an accepted one, and the exclusion of the block's own pin drive. Long random stretches then compare the outputs against a cycle model built from the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  // Strobes from control to datapath: which run counters are armed
  typedef struct packed {
    logic relArm;   // count good-supply samples toward release
    logic dipArm;   // count consecutive Vcc-low samples
    logic extArm;   // count consecutive pin-low samples
  } seqStrobes_t;

endpackage

// File: rtl/run_length_counter.sv
module run_length_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic arstN,
  input  logic active,
  output logic hit
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // hit marks the edge that completes LIMIT consecutive active samples
  assign hit = active && (cnt == LAST);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      cnt <= '0;
    end else if (!active || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int RELEASE_CYCLES  = 20_000_000,
  parameter int DEGLITCH_CYCLES = 4_000,
  parameter int EXT_MIN_CYCLES  = 6_000
) (
  input  logic        clk,
  input  logic        arstN,
  input  seqStrobes_t strobes,
  input  logic        vccOk,
  input  logic        vsAboveHigh,
  input  logic        vsAboveLow,
  input  logic        pinSense,
  output logic        vsNowGood,
  output logic        relHit,
  output logic        dipHit,
  output logic        extHit
);

  logic vsGood;
  logic relActive;
  logic dipActive;
  logic extActive;

  // Vs hysteresis: set by the upper flag, held by the lower flag
  assign vsNowGood = vsAboveHigh | (vsGood & vsAboveLow);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      vsGood <= 1'b0;
    end else begin
      vsGood <= vsNowGood;
    end
  end

  assign relActive = strobes.relArm & vccOk & vsNowGood;
  assign dipActive = strobes.dipArm & ~vccOk;
  assign extActive = strobes.extArm & ~pinSense;

  run_length_counter #(.LIMIT(RELEASE_CYCLES)) u_relCnt (
    .clk(clk), .arstN(arstN), .active(relActive), .hit(relHit)
  );

  run_length_counter #(.LIMIT(DEGLITCH_CYCLES)) u_dipCnt (
    .clk(clk), .arstN(arstN), .active(dipActive), .hit(dipHit)
  );

  run_length_counter #(.LIMIT(EXT_MIN_CYCLES)) u_extCnt (
    .clk(clk), .arstN(arstN), .active(extActive), .hit(extHit)
  );

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        vsNowGood,
  input  logic        relHit,
  input  logic        dipHit,
  input  logic        extHit,
  output seqStrobes_t strobes,
  output logic        holdActive
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      SEQ_HOLD: if (relHit) stateNext = SEQ_RUN;
      SEQ_RUN:  if (!vsNowGood || dipHit || extHit) stateNext = SEQ_HOLD;
      default:  stateNext = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state <= SEQ_HOLD;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobes.relArm = (state == SEQ_HOLD);
    strobes.dipArm = (state == SEQ_RUN);
    strobes.extArm = (state == SEQ_RUN);
  end

  assign holdActive = (state == SEQ_HOLD);

endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer
  import seq_pkg::*;
#(
  parameter int RELEASE_CYCLES  = 20_000_000,
  parameter int DEGLITCH_CYCLES = 4_000,
  parameter int EXT_MIN_CYCLES  = 6_000
) (
  input  logic clk,
  input  logic arstN,
  input  logic vccOk,
  input  logic vsAboveHigh,
  input  logic vsAboveLow,
  input  logic pinSense,
  output logic rstPinLowOut,
  output logic coreResetOut
);

  seqStrobes_t strobes;
  logic vsNowGood;
  logic relHit;
  logic dipHit;
  logic extHit;
  logic holdActive;

  seq_datapath #(
    .RELEASE_CYCLES (RELEASE_CYCLES),
    .DEGLITCH_CYCLES(DEGLITCH_CYCLES),
    .EXT_MIN_CYCLES (EXT_MIN_CYCLES)
  ) u_datapath (
    .clk(clk), .arstN(arstN), .strobes(strobes),
    .vccOk(vccOk), .vsAboveHigh(vsAboveHigh), .vsAboveLow(vsAboveLow),
    .pinSense(pinSense), .vsNowGood(vsNowGood),
    .relHit(relHit), .dipHit(dipHit), .extHit(extHit)
  );

  seq_control u_control (
    .clk(clk), .arstN(arstN), .vsNowGood(vsNowGood),
    .relHit(relHit), .dipHit(dipHit), .extHit(extHit),
    .strobes(strobes), .holdActive(holdActive)
  );

  assign rstPinLowOut = holdActive;
  assign coreResetOut = holdActive;

endmodule

// File: rtl/supply_reset_checker.sv
module supply_reset_checker #(
  parameter int RELEASE_CYCLES = 4
) (
  input logic clk,
  input logic arstN,
  input logic vccOk,
  input logic vsAboveHigh,
  input logic vsAboveLow,
  input logic pinSense,
  input logic rstPinLowOut,
  input logic coreResetOut
);

  localparam int HW = $clog2(RELEASE_CYCLES + 1) + 1;
  localparam logic [HW-1:0] HMAX = HW'(RELEASE_CYCLES);

  logic [HW-1:0] holdLen;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      holdLen <= '0;
    end else if (!rstPinLowOut) begin
      holdLen <= '0;
    end else if (holdLen < HMAX) begin
      holdLen <= holdLen + 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !arstN |-> (rstPinLowOut && coreResetOut));

  assert_release_length_R2: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstPinLowOut) |-> (holdLen >= HMAX));

  assert_bad_vcc_holds_R3: assert property (@(posedge clk) disable iff (!arstN)
    (rstPinLowOut && !vccOk) |=> rstPinLowOut);

  assert_vs_low_holds_R4: assert property (@(posedge clk) disable iff (!arstN)
    (rstPinLowOut && !vsAboveHigh && !vsAboveLow) |=> rstPinLowOut);

  assert_vs_drop_fast_R5: assert property (@(posedge clk) disable iff (!arstN)
    (!rstPinLowOut && !vsAboveLow && !vsAboveHigh) |=> rstPinLowOut);

  assert_no_spurious_assert_R6: assert property (@(posedge clk) disable iff (!arstN)
    (!rstPinLowOut && vccOk && pinSense && vsAboveLow) |=> !rstPinLowOut);

  assert_outputs_agree_R9: assert property (@(posedge clk) disable iff (!arstN)
    coreResetOut == rstPinLowOut);

endmodule

bind supply_reset_sequencer supply_reset_checker #(
  .RELEASE_CYCLES(RELEASE_CYCLES)
) u_checker (
  .clk(clk), .arstN(arstN), .vccOk(vccOk),
  .vsAboveHigh(vsAboveHigh), .vsAboveLow(vsAboveLow),
  .pinSense(pinSense), .rstPinLowOut(rstPinLowOut),
  .coreResetOut(coreResetOut)
);

// File: tb/test_supply_reset_sequencer.sv
`timescale 1ns/1ps
module test_supply_reset_sequencer;

  localparam int REL = 40;
  localparam int DEG = 5;
  localparam int EXT = 7;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic vccOk = 1'b0;
  logic vsHigh = 1'b0;
  logic vsLow = 1'b0;
  logic extDrive = 1'b0;
  logic pinSense;
  logic rstPinLowOut;
  logic coreResetOut;

  int testsRun = 0;
  int testsFailed = 0;

  // Reference model state, built from the requirements
  bit mHold = 1'b1;
  bit mVsGood = 1'b0;
  int mRel = 0;
  int mDip = 0;
  int mExt = 0;

  always #2.5 clk = ~clk;

  // Open-drain wired pin: low if either side pulls
  assign pinSense = ~(rstPinLowOut | extDrive);

  supply_reset_sequencer #(
    .RELEASE_CYCLES(REL), .DEGLITCH_CYCLES(DEG), .EXT_MIN_CYCLES(EXT)
  ) i_supply_reset_sequencer (
    .clk(clk), .arstN(arstN), .vccOk(vccOk),
    .vsAboveHigh(vsHigh), .vsAboveLow(vsLow), .pinSense(pinSense),
    .rstPinLowOut(rstPinLowOut), .coreResetOut(coreResetOut)
  );

  function automatic bit vsNow(bit hi, bit lo, bit prev);
    return hi | (prev & lo);
  endfunction

  always @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      mHold = 1'b1; mVsGood = 1'b0; mRel = 0; mDip = 0; mExt = 0;
    end else begin
      bit vn;
      bit dipHit;
      bit extHit;
      vn = vsNow(vsHigh, vsLow, mVsGood);
      if (mHold) begin
        mDip = 0; mExt = 0;
        if (vccOk && vn) begin
          if (mRel == REL - 1) begin mHold = 1'b0; mRel = 0; end
          else mRel = mRel + 1;
        end else begin
          mRel = 0;
        end
      end else begin
        dipHit = !vccOk && (mDip == DEG - 1);
        extHit = !pinSense && (mExt == EXT - 1);
        mDip = (!vccOk && !dipHit) ? mDip + 1 : 0;
        mExt = (!pinSense && !extHit) ? mExt + 1 : 0;
        if (!vn || dipHit || extHit) mHold = 1'b1;
      end
      mVsGood = vn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock; sample 1 ns after the edge, then compare with the model
  task automatic tick(input string tag);
    @(posedge clk);
    #1;
    check(rstPinLowOut == mHold, tag, rstPinLowOut, mHold);
    check(coreResetOut == rstPinLowOut, "R9 outputs agree", coreResetOut, rstPinLowOut);
  endtask

  task automatic waitRelease(input string tag, output int n);
    n = 0;
    while (rstPinLowOut && n < REL + 50) begin
      tick(tag);
      n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));

    // R1: reset state
    #7;
    check(rstPinLowOut == 1'b1, "R1 pin low in reset", rstPinLowOut, 1);
    check(coreResetOut == 1'b1, "R1 core reset in reset", coreResetOut, 1);
    @(negedge clk);
    arstN = 1'b1;

    // R4: Vs only above lower threshold never counts as good
    vccOk = 1'b1; vsLow = 1'b1; vsHigh = 1'b0;
    repeat (REL + 10) tick("R4 no upper crossing");
    check(rstPinLowOut == 1'b1, "R4 still holding", rstPinLowOut, 1);

    // R2/R4: one upper-threshold sample, then lower flag keeps Vs good
    vsHigh = 1'b1;
    tick("R2 release");
    vsHigh = 1'b0;
    waitRelease("R2 release", n);
    check(n + 1 == REL, "R2 release count", n + 1, REL);

    // R6: dip one short of the window is ignored
    vccOk = 1'b0;
    repeat (DEG - 1) tick("R6 short dip");
    vccOk = 1'b1;
    repeat (10) tick("R6 short dip");
    check(rstPinLowOut == 1'b0, "R6 short dip ignored", rstPinLowOut, 0);

    // R6: full-length dip asserts on its last sample
    vccOk = 1'b0;
    repeat (DEG - 1) tick("R6 long dip");
    check(rstPinLowOut == 1'b0, "R6 before window end", rstPinLowOut, 0);
    tick("R6 long dip");
    check(rstPinLowOut == 1'b1, "R6 dip asserts", rstPinLowOut, 1);

    // R3/R10: restart after a one-cycle bad sample while holding
    vccOk = 1'b1;
    repeat (20) tick("R3 partial");
    vccOk = 1'b0;
    tick("R3 bad sample");
    vccOk = 1'b1;
    waitRelease("R3 restart", n);
    check(n == REL, "R3 restart count", n, REL);

    // R7: short external pulse ignored, long one accepted
    extDrive = 1'b1;
    repeat (EXT - 1) tick("R7 short pulse");
    extDrive = 1'b0;
    repeat (10) tick("R7 short pulse");
    check(rstPinLowOut == 1'b0, "R7 short pulse ignored", rstPinLowOut, 0);
    extDrive = 1'b1;
    repeat (EXT) tick("R7 long pulse");
    check(rstPinLowOut == 1'b1, "R7 pulse asserts", rstPinLowOut, 1);

    // R8: pulling during the hold does not count; release at REL ticks
    repeat (REL - 2) tick("R8 hold with outside pull");
    extDrive = 1'b0;
    tick("R8 hold");
    check(rstPinLowOut == 1'b1, "R8 held to full length", rstPinLowOut, 1);
    tick("R8 release");
    check(rstPinLowOut == 1'b0, "R8 released on time", rstPinLowOut, 0);
    extDrive = 1'b1;
    repeat (EXT - 1) tick("R8 count from release");
    extDrive = 1'b0;
    repeat (5) tick("R8 count from release");
    check(rstPinLowOut == 1'b0, "R8 own drive excluded", rstPinLowOut, 0);

    // R4: upper flag falls, lower still set: no reset
    vsHigh = 1'b1; tick("R4 upper");
    vsHigh = 1'b0; repeat (5) tick("R4 between thresholds");
    check(rstPinLowOut == 1'b0, "R4 hysteresis keeps good", rstPinLowOut, 0);

    // R5: Vs falls below both thresholds: asserts at that edge
    vsLow = 1'b0;
    tick("R5 vs drop");
    check(rstPinLowOut == 1'b1, "R5 immediate assert", rstPinLowOut, 1);
    vsLow = 1'b1;
    repeat (REL + 5) tick("R4 no re-cross");
    check(rstPinLowOut == 1'b1, "R4 needs upper crossing again", rstPinLowOut, 1);

    // R10: random stimulus against the model
    for (int i = 0; i < 6000; i++) begin
      vccOk    = ($urandom % 100) > 2;
      vsHigh   = ($urandom % 100) > 30;
      vsLow    = ($urandom % 200) > 1;
      extDrive = (($urandom % 100) < 3) ? ~extDrive : extDrive;
      tick("R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule